// File: doc/BRIEF.md
# Speculative Alias Check Monitor

This block watches memory operations inside an optimization region and decides whether a compiler's assumption that two accesses do not alias has been broken. It keeps a small fully associative table of cache lines. Each line carries a speculative-read mark, set only by explicit monitoring operations, and a speculative-written mark, set by every store. Checking loads and stores compare against these marks. When a conflict is found, the block requests a rollback and points at the safe-version code.

A region opens with a begin command that carries the safe-version PC. It closes with an end command, which silently drops every mark. Operations arrive as an opcode plus a byte address with a valid strobe. Each accepted operation produces a registered result one cycle later. The rollback is only requested. Carrying it out is left to the surrounding pipeline.

Top module: `alias_monitor`

## Requirements
- R1: A begin command (regionBegin=1) opens a region, discards all marks and captures safePc, including when a region is already open. While rollback is high, restartPc equals the PC captured by the most recent begin. After reset, regionActive, chkDone, chkFail and rollback are 0 and restartPc is 0.
- R2: A plain load (opKind 0) never sets the read mark of its line.
- R3: Every store sets the written mark of its line: plain store (1) and checking stores (4, 5, 6). The written mark stays set until the region closes, including after a clear-read of that line.
- R4: A monitored load (2) sets the read mark of its line. A clear-read (3) resets the read mark of its line.
- R5: Checking stores fail on different marks: opKind 4 fails if the read mark is set, 5 if the written mark is set, 6 if either is set.
- R6: Checking loads fail under the same conditions: opKind 7 on the read mark, 8 on the written mark, 9 on either. Kinds 7 and 9 set the read mark when they pass. Kind 8 does not set it.
- R7: Lines are 64 bytes. Address bits [5:0] play no part in matching.
- R8: An end command (regionEnd=1, regionBegin=0) closes the region and discards every mark. It never causes rollback.
- R9: The table holds 16 lines. An operation that must mark a line not in a full table causes rollback with chkFail=0. A line whose read and written marks are both clear frees its slot.
- R10: chkDone, chkFail and rollback are registered and are due in the cycle after an accepted operation. An operation is accepted when opValid=1, the region is open and there is no begin or end in that cycle. A rollback closes the region, discards marks and lasts one cycle. Later operations are ignored until the next begin.
- R11: An operation outside an open region changes no marks, gives chkDone=0 and never causes rollback.
- R12: Opcodes 10 to 15 are accepted (chkDone=1) but never fail and change no marks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regionBegin | input | 1 | Open a region and capture safePc |
| regionEnd | input | 1 | Close the region |
| safePc | input | PC_W | Safe-version restart address |
| opValid | input | 1 | Operation strobe |
| opKind | input | 4 | Operation code |
| opAddr | input | ADDR_W | Byte address of the operation |
| chkDone | output | 1 | An operation was accepted in the previous cycle |
| chkFail | output | 1 | That operation failed its alias check |
| rollback | output | 1 | Rollback request (alias conflict or table overflow) |
| restartPc | output | PC_W | Safe-version PC to restart from |
| regionActive | output | 1 | A region is open |

## Verification
Every result of this block (chkDone, chkFail, rollback and the closing of regionActive) is due exactly one clock after the edge that accepts the operation. Begin and end commands likewise take effect on regionActive after one edge. The bench drives each operation on a falling edge and lets one rising edge pass. It samples every output on the following falling edge and compares it with a bench model updated in the same step. Mark state is never read directly. It is revealed by later checking operations, whose outcome arrives with that same one-cycle latency.

// File: rtl/alias_mon_pkg.sv
package alias_mon_pkg;

  localparam logic [3:0] OP_LD       = 4'd0;
  localparam logic [3:0] OP_ST       = 4'd1;
  localparam logic [3:0] OP_LDMON    = 4'd2;
  localparam logic [3:0] OP_CLRRD    = 4'd3;
  localparam logic [3:0] OP_STCHK_R  = 4'd4;
  localparam logic [3:0] OP_STCHK_W  = 4'd5;
  localparam logic [3:0] OP_STCHK_RW = 4'd6;
  localparam logic [3:0] OP_LDCHK_R  = 4'd7;
  localparam logic [3:0] OP_LDCHK_W  = 4'd8;
  localparam logic [3:0] OP_LDCHK_RW = 4'd9;

  // strobes from control to the line table
  typedef struct packed {
    logic clearAll;
    logic alloc;
    logic setSr;
    logic setSw;
    logic clrSr;
  } tblStrobe_t;

endpackage

// File: rtl/alias_mon_table.sv
module alias_mon_table
  import alias_mon_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tblStrobe_t       strobe,
  input  logic [TAG_W-1:0] lookupTag,
  output logic             hit,
  output logic             hitSr,
  output logic             hitSw,
  output logic             full
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] entValid, entSr, entSw, matchVec;
  logic [TAG_W-1:0]   entTag [ENTRIES];
  logic [IDX_W-1:0]   hitIdx, freeIdx;

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign matchVec[g] = entValid[g] && (entTag[g] == lookupTag);
  end

  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i])  hitIdx  = IDX_W'(i);
      if (!entValid[i]) freeIdx = IDX_W'(i);
    end
  end

  assign hit   = |matchVec;
  assign hitSr = hit && entSr[hitIdx];
  assign hitSw = hit && entSw[hitIdx];
  assign full  = &entValid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entValid <= '0;
      entSr    <= '0;
      entSw    <= '0;
      for (int i = 0; i < ENTRIES; i++) entTag[i] <= '0;
    end else if (strobe.clearAll) begin
      entValid <= '0;
      entSr    <= '0;
      entSw    <= '0;
    end else if (hit) begin
      if (strobe.setSr) entSr[hitIdx] <= 1'b1;
      if (strobe.setSw) entSw[hitIdx] <= 1'b1;
      if (strobe.clrSr) begin
        entSr[hitIdx] <= 1'b0;
        if (!entSw[hitIdx]) entValid[hitIdx] <= 1'b0;  // slot freed
      end
    end else if (strobe.alloc && !full) begin
      entValid[freeIdx] <= 1'b1;
      entTag[freeIdx]   <= lookupTag;
      entSr[freeIdx]    <= strobe.setSr;
      entSw[freeIdx]    <= strobe.setSw;
    end
  end

  // R9: a line appears in at most one slot
  a_r9_unique_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(matchVec));
  // R9: control never asks for a slot when none is free
  a_r9_alloc_room: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.alloc |-> !full);
  // R9: a held line always carries at least one mark
  a_r9_live_marked: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hitSr || hitSw));

endmodule

// File: rtl/alias_mon_ctrl.sv
module alias_mon_ctrl
  import alias_mon_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            regionBegin,
  input  logic            regionEnd,
  input  logic [PC_W-1:0] safePc,
  input  logic            opValid,
  input  logic [3:0]      opKind,
  input  logic            hit,
  input  logic            hitSr,
  input  logic            hitSw,
  input  logic            full,
  output tblStrobe_t      strobe,
  output logic            chkDone,
  output logic            chkFail,
  output logic            rollback,
  output logic [PC_W-1:0] restartPc,
  output logic            regionActive
);
  logic accept, chkR, chkW, markSr, markSw, clrRd;
  logic conflict, overflow, abort, needEntry;

  assign accept = opValid && regionActive && !regionBegin && !regionEnd;

  always_comb begin
    chkR = 1'b0; chkW = 1'b0; markSr = 1'b0; markSw = 1'b0; clrRd = 1'b0;
    case (opKind)
      OP_ST:       markSw = 1'b1;
      OP_LDMON:    markSr = 1'b1;
      OP_CLRRD:    clrRd  = 1'b1;
      OP_STCHK_R:  begin chkR = 1'b1; markSw = 1'b1; end
      OP_STCHK_W:  begin chkW = 1'b1; markSw = 1'b1; end
      OP_STCHK_RW: begin chkR = 1'b1; chkW = 1'b1; markSw = 1'b1; end
      OP_LDCHK_R:  begin chkR = 1'b1; markSr = 1'b1; end
      OP_LDCHK_W:  chkW = 1'b1;
      OP_LDCHK_RW: begin chkR = 1'b1; chkW = 1'b1; markSr = 1'b1; end
      default: ;
    endcase
  end

  assign needEntry = markSr || markSw;
  assign conflict  = accept && ((chkR && hitSr) || (chkW && hitSw));
  assign overflow  = accept && !conflict && needEntry && !hit && full;
  assign abort     = conflict || overflow;

  always_comb begin
    strobe.clearAll = regionBegin || regionEnd || abort;
    strobe.setSr    = accept && !abort && markSr;
    strobe.setSw    = accept && !abort && markSw;
    strobe.clrSr    = accept && clrRd;
    strobe.alloc    = accept && !abort && needEntry && !hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regionActive <= 1'b0;
      restartPc    <= '0;
      chkDone      <= 1'b0;
      chkFail      <= 1'b0;
      rollback     <= 1'b0;
    end else begin
      if (regionBegin) begin
        regionActive <= 1'b1;
        restartPc    <= safePc;
      end else if (regionEnd || abort) begin
        regionActive <= 1'b0;
      end
      chkDone  <= accept;
      chkFail  <= conflict;
      rollback <= abort;
    end
  end

  // R11: nothing is reported for operations outside a region
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !regionActive |=> (!rollback && !chkDone));
  // R8: closing a region never requests rollback
  a_r8_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (regionEnd && !regionBegin) |=> !rollback);
  // R10: rollback leaves the region closed and lasts one cycle
  a_r10_rb_closes: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |-> (!regionActive && chkDone));
  a_r10_rb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |=> !rollback);
  // R1: restart target is not disturbed while rollback is presented
  a_r1_pc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |-> $stable(restartPc));

endmodule

// File: rtl/alias_monitor.sv
module alias_monitor
  import alias_mon_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int ENTRIES    = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regionBegin,
  input  logic              regionEnd,
  input  logic [PC_W-1:0]   safePc,
  input  logic              opValid,
  input  logic [3:0]        opKind,
  input  logic [ADDR_W-1:0] opAddr,
  output logic              chkDone,
  output logic              chkFail,
  output logic              rollback,
  output logic [PC_W-1:0]   restartPc,
  output logic              regionActive
);
  localparam int LINE_BITS = $clog2(LINE_BYTES);
  localparam int TAG_W     = ADDR_W - LINE_BITS;

  tblStrobe_t       strobe;
  logic             hit, hitSr, hitSw, full;
  logic [TAG_W-1:0] lineTag;
  logic             unusedLowBits;

  assign lineTag       = opAddr[ADDR_W-1:LINE_BITS];
  assign unusedLowBits = ^opAddr[LINE_BITS-1:0];

  alias_mon_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regionBegin(regionBegin), .regionEnd(regionEnd), .safePc(safePc),
    .opValid(opValid), .opKind(opKind),
    .hit(hit), .hitSr(hitSr), .hitSw(hitSw), .full(full),
    .strobe(strobe),
    .chkDone(chkDone), .chkFail(chkFail), .rollback(rollback),
    .restartPc(restartPc), .regionActive(regionActive)
  );

  alias_mon_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .lookupTag(lineTag),
    .hit(hit), .hitSr(hitSr), .hitSw(hitSw), .full(full)
  );

endmodule

// File: tb/alias_monitor_test.sv
module alias_monitor_test;
  import alias_mon_pkg::*;

  localparam int NENT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regionBegin = 1'b0, regionEnd = 1'b0, opValid = 1'b0;
  logic [31:0] safePc = '0, opAddr = '0;
  logic [3:0]  opKind = '0;
  logic        chkDone, chkFail, rollback, regionActive;
  logic [31:0] restartPc;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model of the mark table
  logic        mV [NENT], mSr [NENT], mSw [NENT];
  logic [25:0] mTag [NENT];
  logic        mAct = 1'b0;
  logic [31:0] mPc = '0;

  always #4 clk = ~clk;

  alias_monitor uut (
    .clk(clk), .rst_n(rst_n), .regionBegin(regionBegin), .regionEnd(regionEnd),
    .safePc(safePc), .opValid(opValid), .opKind(opKind), .opAddr(opAddr),
    .chkDone(chkDone), .chkFail(chkFail), .rollback(rollback),
    .restartPc(restartPc), .regionActive(regionActive)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < NENT; i++) begin
      mV[i] = 0; mSr[i] = 0; mSw[i] = 0; mTag[i] = '0;
    end
  endtask

  task automatic modelOp(input logic b, input logic e, input logic v,
                         input logic [3:0] k, input logic [31:0] a,
                         input logic [31:0] pc,
                         output logic xDone, output logic xFail, output logic xRb);
    logic cr, cw, ms, mw, cl, fullT;
    int hi, fr;
    xDone = 0; xFail = 0; xRb = 0;
    if (b) begin
      modelClear(); mAct = 1; mPc = pc;
    end else if (e) begin
      modelClear(); mAct = 0;
    end else if (v && mAct) begin
      xDone = 1;
      cr = (k == 4) || (k == 6) || (k == 7) || (k == 9);
      cw = (k == 5) || (k == 6) || (k == 8) || (k == 9);
      ms = (k == 2) || (k == 7) || (k == 9);
      mw = (k == 1) || (k == 4) || (k == 5) || (k == 6);
      cl = (k == 3);
      hi = -1; fr = -1; fullT = 1;
      for (int i = 0; i < NENT; i++) begin
        if (mV[i] && mTag[i] == a[31:6]) hi = i;
        if (!mV[i]) begin fullT = 0; if (fr < 0) fr = i; end
      end
      if (hi >= 0 && ((cr && mSr[hi]) || (cw && mSw[hi]))) begin
        xFail = 1; xRb = 1; modelClear(); mAct = 0;
      end else if ((ms || mw) && hi < 0 && fullT) begin
        xRb = 1; modelClear(); mAct = 0;
      end else if (hi >= 0) begin
        if (ms) mSr[hi] = 1;
        if (mw) mSw[hi] = 1;
        if (cl) begin mSr[hi] = 0; if (!mSw[hi]) mV[hi] = 0; end
      end else if (ms || mw) begin
        mV[fr] = 1; mTag[fr] = a[31:6]; mSr[fr] = ms; mSw[fr] = mw;
      end
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input logic b, input logic e, input logic v,
                      input logic [3:0] k, input logic [31:0] a,
                      input logic [31:0] pc, input string req);
    logic xDone, xFail, xRb;
    regionBegin = b; regionEnd = e; opValid = v; opKind = k; opAddr = a; safePc = pc;
    modelOp(b, e, v, k, a, pc, xDone, xFail, xRb);
    @(posedge clk);
    @(negedge clk);
    check(req, "chkDone", 32'(chkDone), 32'(xDone));
    check(req, "chkFail", 32'(chkFail), 32'(xFail));
    check(req, "rollback", 32'(rollback), 32'(xRb));
    check(req, "regionActive", 32'(regionActive), 32'(mAct));
    if (xRb) check(req, "restartPc", restartPc, mPc);
  endtask

  task automatic op(input logic [3:0] k, input logic [31:0] a, input string req);
    step(0, 0, 1, k, a, 32'h0, req);
  endtask

  task automatic openRegion(input logic [31:0] pc, input string req);
    step(1, 0, 0, 4'd0, 32'h0, pc, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset regionActive", 32'(regionActive), 0);
    check("R1", "reset rollback", 32'(rollback), 0);
    check("R10", "reset chkDone", 32'(chkDone), 0);
    check("R1", "reset restartPc", restartPc, 0);

    // R11: store outside a region leaves no mark
    op(OP_ST, 32'h1000, "R11");
    openRegion(32'h4000_0100, "R1");
    op(OP_LDCHK_W, 32'h1000, "R11");

    // R2: plain load does not mark the line
    op(OP_LD, 32'h2000, "R2");
    op(OP_STCHK_R, 32'h2000, "R2");

    // R4 + R7 + R5: monitored line conflicts at a different offset
    op(OP_LDMON, 32'h3000, "R4");
    op(OP_STCHK_R, 32'h3010, "R7");
    op(OP_ST, 32'h3000, "R10");            // ignored after rollback
    openRegion(32'h4000_0200, "R1");
    op(OP_LDCHK_W, 32'h3000, "R10");       // earlier marks gone

    // R4: clear-read removes the read mark
    op(OP_LDMON, 32'h3000, "R4");
    op(OP_CLRRD, 32'h3020, "R4");
    op(OP_STCHK_R, 32'h3000, "R4");
    op(OP_STCHK_W, 32'h3000, "R3");        // store just set SW

    // R3: written mark survives a clear-read
    openRegion(32'h4000_0300, "R1");
    op(OP_ST, 32'h5000, "R3");
    op(OP_LDMON, 32'h5000, "R3");
    op(OP_CLRRD, 32'h5000, "R3");
    op(OP_LDCHK_W, 32'h5000, "R3");

    // R6: kind 7 sets SR, kind 8 does not, kind 9 does
    openRegion(32'h4000_0400, "R1");
    op(OP_LDCHK_R, 32'h6000, "R6");
    op(OP_STCHK_R, 32'h6000, "R6");
    openRegion(32'h4000_0500, "R1");
    op(OP_LDCHK_W, 32'h7000, "R6");
    op(OP_STCHK_R, 32'h7000, "R6");
    op(OP_STCHK_RW, 32'h7000, "R5");
    openRegion(32'h4000_0600, "R1");
    op(OP_LDCHK_RW, 32'h8000, "R6");
    op(OP_LDCHK_R, 32'h8000, "R6");

    // R8: end drops marks, no rollback
    openRegion(32'h4000_0700, "R1");
    op(OP_ST, 32'h9000, "R8");
    step(0, 1, 0, 4'd0, 32'h0, 32'h0, "R8");
    openRegion(32'h4000_0800, "R1");
    op(OP_STCHK_W, 32'h9000, "R8");

    // R12: undefined codes change nothing
    op(4'd12, 32'hA000, "R12");
    op(4'd15, 32'hA000, "R12");
    op(OP_LDCHK_RW, 32'hA000, "R12");

    // R9: overflow on the 17th line
    openRegion(32'h4000_0900, "R1");
    for (int i = 0; i < NENT; i++) op(OP_ST, 32'h10000 + 32'(i * 64), "R9");
    op(OP_ST, 32'h20000, "R9");
    // R9: freeing a read-only slot makes room
    openRegion(32'h4000_0A00, "R1");
    for (int i = 0; i < NENT; i++) op(OP_LDMON, 32'h10000 + 32'(i * 64), "R9");
    op(OP_CLRRD, 32'h10000, "R9");
    op(OP_LDMON, 32'h30000, "R9");
    op(OP_ST, 32'h10040, "R9");

    // R1: a second begin replaces the PC and marks
    openRegion(32'h4000_0B00, "R1");
    op(OP_LDMON, 32'hB000, "R1");
    openRegion(32'h4000_0C00, "R1");
    op(OP_STCHK_R, 32'hB000, "R1");
    op(OP_LDMON, 32'hB000, "R1");
    op(OP_STCHK_RW, 32'hB004, "R1");

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [31:0] a;
      r = int'($urandom % 100);
      a = 32'h40000 + (($urandom % 20) << 6) + ($urandom % 64);
      if (r < 3 || (!mAct && r < 20))
        step(1, 0, 0, 4'd0, 32'h0, 32'h5000_0000 + 32'(n), "R10");
      else if (r < 5)
        step(0, 1, 0, 4'd0, 32'h0, 32'h0, "R8");
      else
        step(0, 0, (r % 7) != 0, 4'($urandom % 13), a, 32'h0, "R10");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule